// File: doc/BRIEF.md
# Wrapping One-Hot Priority Selector

This block picks one requester out of a vector of requests. The caller also gives a one-hot start marker that names the first position to look at. The block scans upward from that position toward the most significant bit, wraps around to bit 0, and stops at the first asserted request. It returns that position as a one-hot grant. The block is purely combinational and holds no state. The caller produces the start marker. A typical caller sets the marker to the previous winner shifted left by one place, which turns the block into the core of a round-robin arbiter.

The scan uses no loop and no rotator. The request vector is placed side by side with a copy of itself to form a word of twice the width. The start marker is subtracted from that word. The borrow passes through the zero bits and is absorbed at the first set bit at or above the marker. ANDing the doubled word with the inverse of the difference leaves only that bit set. A final OR folds the upper half of the result onto the lower half. This fold is what makes a winner below the marker wrap around into the correct position. There is no state machine and no clock or reset. Behaviour is defined only for a one-hot start marker.

Top module: `psel_rr_pick`

## Requirements
- R1: `grant_o` never has more than one bit set.
- R2: When `req_i` is all zero, `grant_o` is all zero for any one-hot `base_i`.
- R3: Every set bit of `grant_o` is also set in `req_i`.
- R4: When the request bit at the position marked by `base_i` is set, `grant_o` equals `base_i`.
- R5: When `req_i` is non-zero, `grant_o` has exactly one bit set.
- R6: The granted position is the first set request found by scanning the indices base, base+1, …, WIDTH-1, 0, …, base-1. Here bit i of each vector stands for requester i, and base is the index of the single set bit of `base_i`.
- R7: Wrap-around: when every set request lies below the base, the lowest set request is granted. For example, with WIDTH=4, `req_i`=0001 and `base_i`=0100 give 0001.
- R8: With WIDTH=4 and `base_i`=0010, the requests 1001, 0010, 0011, 0110 and 0101 produce the grants 1000, 0010, 0010, 0010 and 0100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| req_i | input | WIDTH | Request vector, bit i for requester i |
| base_i | input | WIDTH | One-hot start marker for the scan |
| grant_o | output | WIDTH | One-hot grant, or zero when no request is set |

## Verification
At WIDTH=4 the bench sweeps all 16 request vectors against each of the 4 one-hot markers. It compares each result with an upward wrapping index scan. The all-zero request separates a correct empty result from a spurious grant. Requests that contain the marker bit check that the scan starts at the marker and not at bit 0. Requests that lie only below the marker exercise the fold, which a design without the doubled word would miss. The listed fixed vectors are also checked individually so that a failure points at a specific case.

// File: rtl/psel_pkg.sv
package psel_pkg;
    // Smallest supported request width
    localparam int unsigned PSEL_MIN_WIDTH = 2;
endpackage

// File: rtl/psel_borrow_mask.sv
module psel_borrow_mask #(
    parameter int unsigned WIDTH = 4,
    localparam int unsigned DBL = 2 * WIDTH
) (
    input  logic [WIDTH-1:0] req_i,
    input  logic [WIDTH-1:0] base_i,
    output logic [DBL-1:0]   hit_o
);
    logic [DBL-1:0] dbl_req;
    logic [DBL-1:0] base_ext;
    logic [DBL-1:0] diff;

    always_comb begin
        dbl_req  = {req_i, req_i};
        base_ext = {{WIDTH{1'b0}}, base_i};
        // borrow ripples through zeros, absorbed at first set bit
        diff     = dbl_req - base_ext;
        hit_o    = dbl_req & ~diff;
    end
endmodule

// File: rtl/psel_fold.sv
module psel_fold #(
    parameter int unsigned WIDTH = 4,
    localparam int unsigned DBL = 2 * WIDTH
) (
    input  logic [DBL-1:0]   hit_i,
    output logic [WIDTH-1:0] grant_o
);
    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_fold
            assign grant_o[gi] = hit_i[gi] | hit_i[gi+WIDTH];
        end
    endgenerate
endmodule

// File: rtl/psel_rr_pick.sv
module psel_rr_pick #(
    parameter int unsigned WIDTH = 4
) (
    input  logic [WIDTH-1:0] req_i,
    input  logic [WIDTH-1:0] base_i,
    output logic [WIDTH-1:0] grant_o
);
    import psel_pkg::*;
    localparam int unsigned DBL = 2 * WIDTH;

    generate
        if (WIDTH < PSEL_MIN_WIDTH) begin : g_bad_width
            initial $display("psel_rr_pick: WIDTH below minimum");
        end
    endgenerate

    logic [DBL-1:0] hit;

    psel_borrow_mask #(.WIDTH(WIDTH)) u_mask (
        .req_i  (req_i),
        .base_i (base_i),
        .hit_o  (hit)
    );

    psel_fold #(.WIDTH(WIDTH)) u_fold (
        .hit_i   (hit),
        .grant_o (grant_o)
    );
endmodule

// File: rtl/psel_rr_pick_chk.sv
module psel_rr_pick_chk #(
    parameter int unsigned WIDTH = 4
) (
    input logic [WIDTH-1:0] req_i,
    input logic [WIDTH-1:0] base_i,
    input logic [WIDTH-1:0] grant_o
);
    logic base_ok;
    assign base_ok = $onehot(base_i);

    always_comb begin
        if (base_ok) begin
            AST_GRANT_ONEHOT0: assert ($onehot0(grant_o));                        // R1
            AST_IDLE_NO_GRANT: assert ((req_i != '0) || (grant_o == '0));         // R2
            AST_GRANT_IN_REQ:  assert ((grant_o & ~req_i) == '0);                 // R3
            AST_BASE_WINS:     assert (((req_i & base_i) == '0) || (grant_o == base_i)); // R4
            AST_ONE_WINNER:    assert ((req_i == '0) || ($countones(grant_o) == 1)); // R5
        end
    end
endmodule

bind psel_rr_pick psel_rr_pick_chk #(.WIDTH(WIDTH)) u_chk (
    .req_i   (req_i),
    .base_i  (base_i),
    .grant_o (grant_o)
);

// File: tb/tb_psel_rr_pick.sv
module tb_psel_rr_pick;
    localparam int W = 4;

    logic clk = 1'b0;
    logic [W-1:0] req;
    logic [W-1:0] base;
    logic [W-1:0] grant;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    psel_rr_pick #(.WIDTH(W)) dut (
        .req_i   (req),
        .base_i  (base),
        .grant_o (grant)
    );

    function automatic logic [W-1:0] ref_pick(logic [W-1:0] r, int b);
        for (int k = 0; k < W; k++) begin
            if (r[(b + k) % W]) return (W'(1) << ((b + k) % W));
        end
        return '0;
    endfunction

    task automatic apply_check(logic [W-1:0] r, logic [W-1:0] bs,
                               logic [W-1:0] exp, string tag);
        @(negedge clk);
        req  = r;
        base = bs;
        #2;
        checks++;
        if (grant !== exp) begin
            failures++;
            $display("FAIL %s req=%b base=%b actual=%b expected=%b",
                     tag, r, bs, grant, exp);
        end
    endtask

    initial begin
        req = '0;
        base = 4'b0001;
        // idle state at start: no request, no grant (R2)
        apply_check(4'b0000, 4'b0001, 4'b0000, "R2");
        // fixed vectors (R8)
        apply_check(4'b1001, 4'b0010, 4'b1000, "R8");
        apply_check(4'b0010, 4'b0010, 4'b0010, "R8");
        apply_check(4'b0011, 4'b0010, 4'b0010, "R8");
        apply_check(4'b0110, 4'b0010, 4'b0010, "R8");
        apply_check(4'b0101, 4'b0010, 4'b0100, "R8");
        // wrap below base (R7)
        apply_check(4'b0001, 4'b0100, 4'b0001, "R7");
        apply_check(4'b0011, 4'b1000, 4'b0001, "R7");
        apply_check(4'b0110, 4'b1000, 4'b0010, "R7");
        // base position granted when requested (R4)
        apply_check(4'b1111, 4'b1000, 4'b1000, "R4");
        // exhaustive sweep vs wrapping index scan (R6, R1, R3, R5, R2)
        for (int b = 0; b < W; b++) begin
            for (int r = 0; r < (1 << W); r++) begin
                apply_check(W'(r), W'(1) << b, ref_pick(W'(r), b), "R6");
            end
        end
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 20000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired before sweep finished");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule